// File: doc/BRIEF.md
# Sidetone Filter Coefficient Loader

This block is the register front end of an audio sidetone unit. Software reaches it through a 32-bit register port with separate write and read strobes. It holds the sidetone on/off bit, a clock auto-idle bit, and one 16-bit gain field for each of two channels. It drives all of these to a separate filter datapath, which is not part of this block.

The filter taps are loaded through a single data register. Software sets the load-enable bit in the control register, which rewinds an internal tap index. Software then writes the data register once per tap. Each write stores the low bits as one signed coefficient and moves the index on by one. After the final tap the block raises a done flag, which software polls. The datapath reads the stored taps through a separate combinational read port, addressed by tap number.

Top module: `sidetone_coef_loader`

## Requirements
- R1: After reset, the control and gain registers read 0, the system configuration register reads 1 (auto-idle set), `idle_allow` is 1, `tone_on` is 0, and every tap reads 0.
- R2: The revision register at offset 0x00 reads the constant `REV_ID`. Writes to it change nothing.
- R3: Bit 0 of the system configuration register at offset 0x10 is the auto-idle bit. It reads back there, and it drives `idle_allow` from the cycle after the write. The other bits of that register read 0.
- R4: The gain register at offset 0x24 holds the channel 0 gain in bits 15:0 and the channel 1 gain in bits 31:16. It reads back as written, and it drives `gain_ch0` and `gain_ch1` from the cycle after the write.
- R5: The control register is at offset 0x2C. Bit 0 is the sidetone enable and drives `tone_on` from the cycle after the write. Bit 1 is the coefficient load enable. Bit 2 is the read-only done flag. Bits 31:3 read 0.
- R6: A control write that changes the load enable from 0 to 1 sets the tap index to 0 and clears the done flag. A control write that leaves the load enable at 1 changes neither.
- R7: While the load enable is 1 and the done flag is 0, each write to the data register at offset 0x28 stores bits 15:0 into the tap at the current index, then advances the index by one.
- R8: The write that fills the last tap (`NUM_TAPS`, default 128) sets the done flag. Further data writes leave every tap unchanged.
- R9: While the load enable is 0, data writes leave every tap unchanged. Clearing the load enable keeps the table and the done flag unchanged.
- R10: `bus_rdata` is registered and shows the register addressed by a read strobe in the cycle after the strobe. The data register, the offsets 0x18 and 0x1C, and any unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tap_rd_idx | input | IDX_W (7) | Tap number for the datapath read port |
| tap_rd_data | output | COEF_W (16) | Signed tap value at `tap_rd_idx` |
| gain_ch0 | output | 16 | Channel 0 sidetone gain |
| gain_ch1 | output | 16 | Channel 1 sidetone gain |
| tone_on | output | 1 | Sidetone enable to the datapath |
| idle_allow | output | 1 | Clock auto-idle permitted |

## Verification
On every cycle, assertions check the following:
- an accepted tap write advances the index by exactly one;
- the final tap write raises the done flag;
- a load start rewinds the index and clears the done flag;
- a refused data write moves neither the index nor the done flag;
- the done flag stays set until the next load start;
- the gain and auto-idle registers, and the revision readback, follow the write or read from the cycle before.

Some behaviours can only be shown by the bench scenarios, because they depend on what the table actually holds:
- that each coefficient lands at the right tap;
- that writes after the done flag, or with the load enable clear, leave the whole table intact;
- that a second load overwrites only the taps it reaches.

// File: rtl/stl_pkg.sv
package stl_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int GAIN_W = 16;

  localparam logic [ADDR_W-1:0] OFS_REV    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SYSCFG = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_GAIN   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_COEF   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h2C;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_WREN_BIT = 1;
  localparam int CTRL_DONE_BIT = 2;

  // A control write that raises the load enable starts a new load
  function automatic logic load_begins(logic ctrl_wr, logic new_wren, logic cur_wren);
    return ctrl_wr & new_wren & ~cur_wren;
  endfunction

  // Tap index after one accepted write
  function automatic int unsigned tap_next(int unsigned idx);
    return idx + 1;
  endfunction

  // Control register readback image
  function automatic logic [DATA_W-1:0] ctrl_image(logic en, logic wren, logic done);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CTRL_EN_BIT]   = en;
    v[CTRL_WREN_BIT] = wren;
    v[CTRL_DONE_BIT] = done;
    return v;
  endfunction

endpackage

// File: rtl/stl_regs.sv
module stl_regs
  import stl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_en,
  output logic              ctrl_wren,
  output logic              auto_idle,
  output logic [GAIN_W-1:0] gain0,
  output logic [GAIN_W-1:0] gain1,
  output logic              load_start
);

  logic wr_ctrl, wr_gain, wr_sys;

  assign wr_ctrl    = wr_en && (addr == OFS_CTRL);
  assign wr_gain    = wr_en && (addr == OFS_GAIN);
  assign wr_sys     = wr_en && (addr == OFS_SYSCFG);
  assign load_start = load_begins(wr_ctrl, wdata[CTRL_WREN_BIT], ctrl_wren);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_wren <= 1'b0;
      auto_idle <= 1'b1;
      gain0     <= '0;
      gain1     <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en   <= wdata[CTRL_EN_BIT];
        ctrl_wren <= wdata[CTRL_WREN_BIT];
      end
      if (wr_sys) auto_idle <= wdata[0];
      if (wr_gain) begin
        gain0 <= wdata[GAIN_W-1:0];
        gain1 <= wdata[2*GAIN_W-1:GAIN_W];
      end
    end
  end

  assert_gain_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gain |=> (gain0 == $past(wdata[GAIN_W-1:0])) && (gain1 == $past(wdata[2*GAIN_W-1:GAIN_W])));

  assert_idle_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sys |=> auto_idle == $past(wdata[0]));

  assert_enable_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_en == $past(wdata[CTRL_EN_BIT]));

endmodule

// File: rtl/stl_coef_table.sv
module stl_coef_table #(
  parameter int NUM_TAPS = 128,
  parameter int COEF_W   = 16,
  localparam int IDX_W   = $clog2(NUM_TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              wren,
  input  logic              data_wr,
  input  logic [COEF_W-1:0] data_in,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [COEF_W-1:0] rd_data,
  output logic              done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);

  logic [COEF_W-1:0] taps [NUM_TAPS];
  logic [IDX_W-1:0]  idx;
  logic              take;
  logic              at_last;

  assign take    = data_wr && wren && !done;
  assign at_last = (idx == LAST_IDX);
  assign rd_data = taps[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      done <= 1'b0;
      for (int k = 0; k < NUM_TAPS; k++) taps[k] <= '0;
    end else if (load_start) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (take) begin
      taps[idx] <= data_in;
      if (at_last) done <= 1'b1;
      else         idx  <= IDX_W'(stl_pkg::tap_next(int'(idx)));
    end
  end

  assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !at_last && !load_start) |=> idx == IDX_W'($past(idx) + 1'b1));

  assert_done_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && at_last && !load_start) |=> done);

  assert_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> (idx == '0) && !done);

  assert_refused_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !take && !load_start) |=> $stable(idx) && $stable(done));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load_start) |=> done);

endmodule

// File: rtl/sidetone_coef_loader.sv
module sidetone_coef_loader
  import stl_pkg::*;
#(
  parameter int            NUM_TAPS = 128,
  parameter int            COEF_W   = 16,
  parameter logic [31:0]   REV_ID   = 32'h5E71_0003,
  localparam int           IDX_W    = $clog2(NUM_TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IDX_W-1:0]  tap_rd_idx,
  output logic [COEF_W-1:0] tap_rd_data,
  output logic [15:0]       gain_ch0,
  output logic [15:0]       gain_ch1,
  output logic              tone_on,
  output logic              idle_allow
);

  logic ctrl_wren, load_start, coef_done, coef_wr;
  logic [DATA_W-1:0] rd_mux;

  assign coef_wr = bus_wr && (bus_addr == OFS_COEF);

  stl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .ctrl_en    (tone_on),
    .ctrl_wren  (ctrl_wren),
    .auto_idle  (idle_allow),
    .gain0      (gain_ch0),
    .gain1      (gain_ch1),
    .load_start (load_start)
  );

  stl_coef_table #(.NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start),
    .wren       (ctrl_wren),
    .data_wr    (coef_wr),
    .data_in    (bus_wdata[COEF_W-1:0]),
    .rd_idx     (tap_rd_idx),
    .rd_data    (tap_rd_data),
    .done       (coef_done)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_REV:    rd_mux = REV_ID;
      OFS_SYSCFG: rd_mux = {{(DATA_W-1){1'b0}}, idle_allow};
      OFS_GAIN:   rd_mux = {gain_ch1, gain_ch0};
      OFS_CTRL:   rd_mux = ctrl_image(tone_on, ctrl_wren, coef_done);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_rev_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_REV) |=> bus_rdata == REV_ID);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !$past(!rst_n)) |=> $stable(bus_rdata));

endmodule

// File: tb/sidetone_coef_loader_test.sv
module sidetone_coef_loader_test;

  localparam logic [31:0] REV = 32'h5E71_0003;
  localparam int NT = 128;

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h00, 32'hFFFF_FFFF, REV},          // R2 write ignored
    '{8'h10, 32'h0000_0000, 32'h0},        // R3
    '{8'h10, 32'hFFFF_FFFE, 32'h0},        // R3 only bit 0 kept
    '{8'h10, 32'h0000_0003, 32'h1},        // R3
    '{8'h24, 32'h8001_7FFF, 32'h8001_7FFF},// R4
    '{8'h2C, 32'h0000_0001, 32'h1},        // R5
    '{8'h2C, 32'h0000_0005, 32'h1},        // R5 done bit read-only
    '{8'h18, 32'h0000_0012, 32'h0},        // R10
    '{8'h34, 32'h0000_FFFF, 32'h0}         // R10 unmapped
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [6:0] tap_rd_idx = '0;
  logic [15:0] tap_rd_data, gain_ch0, gain_ch1;
  logic tone_on, idle_allow;
  int total = 0, bad = 0;
  logic [15:0] exp_tab [NT];

  always #4 clk = ~clk;

  sidetone_coef_loader uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tap_rd_idx(tap_rd_idx), .tap_rd_data(tap_rd_data),
    .gain_ch0(gain_ch0), .gain_ch1(gain_ch1),
    .tone_on(tone_on), .idle_allow(idle_allow)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [15:0] pat_a(int i); return 16'(i * 517 - 30000); endfunction
  function automatic logic [15:0] pat_b(int i); return 16'(i * 3 + 7); endfunction

  task automatic tap_check(input string req, input int i);
    @(negedge clk); tap_rd_idx = 7'(i); #1;
    check(req, {16'h0, tap_rd_data}, {16'h0, exp_tab[i]});
  endtask

  task automatic all_taps(input string req);
    int miss = 0;
    for (int i = 0; i < NT; i++) begin
      tap_rd_idx = 7'(i); #1;
      if (tap_rd_data !== exp_tab[i]) miss++;
    end
    check(req, 32'(miss), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NT; i++) exp_tab[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h2C, v); check("R1 ctrl", v, 32'h0);
    rd(8'h24, v); check("R1 gain", v, 32'h0);
    rd(8'h10, v); check("R1 syscfg", v, 32'h1);
    check("R1 outputs", {29'h0, idle_allow, tone_on, 1'b0}, {29'h0, 1'b1, 1'b0, 1'b0});
    all_taps("R1 taps zero");

    // Vector walk: R2 R3 R4 R5 R10
    for (int k = 0; k < 9; k++) begin
      wr(VECS[k].a, VECS[k].w);
      rd(VECS[k].a, v);
      check($sformatf("R2/R3/R4/R5/R10 vector %0d", k), v, VECS[k].e);
    end
    check("R4 gain_ch0 out", {16'h0, gain_ch0}, 32'h7FFF);
    check("R4 gain_ch1 out", {16'h0, gain_ch1}, 32'h8001);
    check("R5 tone_on out", {31'h0, tone_on}, 32'h1);
    check("R3 idle_allow out", {31'h0, idle_allow}, 32'h1);
    wr(8'h10, 32'h0);
    check("R3 idle_allow cleared", {31'h0, idle_allow}, 32'h0);
    wr(8'h2C, 32'h0);
    check("R5 tone_on cleared", {31'h0, tone_on}, 32'h0);

    // Full load: R6 R7 R8
    wr(8'h2C, 32'h3);
    rd(8'h2C, v); check("R6 load start", v, 32'h3);
    for (int i = 0; i < NT - 1; i++) begin
      wr(8'h28, {16'hABCD, pat_a(i)});
      exp_tab[i] = pat_a(i);
    end
    rd(8'h2C, v); check("R8 not done before last", v, 32'h3);
    wr(8'h28, {16'h0, pat_a(NT - 1)}); exp_tab[NT - 1] = pat_a(NT - 1);
    rd(8'h2C, v); check("R8 done after last", v, 32'h7);
    rd(8'h28, v); check("R10 coef reads zero", v, 32'h0);
    all_taps("R7 full table");
    wr(8'h28, 32'h1111);
    tap_check("R8 extra write tap0", 0);
    tap_check("R8 extra write tap127", NT - 1);
    all_taps("R8 table intact");

    // R9 clear load enable
    wr(8'h2C, 32'h1);
    rd(8'h2C, v); check("R9 done kept", v, 32'h5);
    wr(8'h28, 32'h2222);
    all_taps("R9 write with enable clear ignored");

    // R6 reload, partial
    wr(8'h2C, 32'h3);
    rd(8'h2C, v); check("R6 done cleared", v, 32'h3);
    for (int i = 0; i < 3; i++) begin
      wr(8'h28, {16'h0, pat_b(i)});
      exp_tab[i] = pat_b(i);
    end
    wr(8'h2C, 32'h3);   // no rising edge: index keeps going
    wr(8'h28, {16'h0, pat_b(3)}); exp_tab[3] = pat_b(3);
    tap_check("R6 no rewind without rise", 3);
    tap_check("R7 tap4 old", 4);
    all_taps("R7 partial reload");

    // R1 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < NT; i++) exp_tab[i] = '0;
    all_taps("R1 table cleared");
    rd(8'h2C, v); check("R1 ctrl after reset", v, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule